// File: doc/BRIEF.md
# Corrected-Error Address Log Table

This block keeps a small table of the word addresses at which a memory's error-correcting logic repaired a single-bit fault. It also raises an interrupt, and the programmed mode decides when. Each error report is one strobe with its address. The block first aligns that address to a data-word boundary. It then compares the aligned address with every valid entry in the same cycle, and stores it only if no valid entry already holds it. Storage takes the lowest free slot.

Two mode bits choose the interrupt policy. With logging off, every report raises the interrupt and the table is left alone. With logging on, the interrupt comes either from each newly stored address or only from an address that finds the table full. A pending bit holds the interrupt until software writes one to clear it, and an enable bit gates the request line. A table-clear strobe empties the table and drops the sticky overflow flag. The latest raw error address is always kept, whatever the mode.

Top module: `ce_addr_log`

## Requirements
- R1: A stored address has its low `ALIGN` bits forced to zero. Two addresses in the same data word count as the same entry.
- R2: With `log_mode_i` = 0, every `err_valid_i` strobe is an interrupt event. The entry valid bits and `ovf_o` do not change.
- R3: With `log_mode_i` = 1 and `ovf_only_i` = 0, only an address that gets stored is an interrupt event. A repeated address is not an event. A new address that meets a full table is dropped with no event, and `ovf_o` stays 0.
- R4: With `log_mode_i` = 1 and `ovf_only_i` = 1, storing an address is not an event. A new address that meets a full table sets `ovf_o` and is an event. With the default depth of 4, this happens on the fifth distinct address.
- R5: An aligned address that matches a valid entry is not stored again. Invalid entries take no part in the comparison.
- R6: On every strobe, in any mode, `last_addr_o` holds the raw `err_addr_i` from the cycle after the strobe.
- R7: New addresses fill the slots from index 0 upward in order of arrival. Slot i sits at `entry_addr_o[i*ADDR_W +: ADDR_W]`, and its valid bit is `entry_valid_o[i]`.
- R8: An interrupt event sets `pend_o` on the next cycle only while `irq_en_i` = 1. `irq_o` equals `pend_o` AND `irq_en_i`.
- R9: `pend_clr_i` = 1 clears `pend_o` on the next cycle. If an interrupt event is registered in the same cycle, the pending bit stays set.
- R10: `ovf_o` is sticky, and while the table is full every further new address is dropped. `tbl_clr_i` clears all valid bits and `ovf_o`.
- R11: When `tbl_clr_i` and a logged error come in the same cycle, the clear acts first and the address is stored in slot 0 of the emptied table.
- R12: After synchronous reset, `irq_o`, `pend_o`, `ovf_o`, `last_addr_o`, the valid bits and the entry addresses are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid_i | input | 1 | Corrected single-bit error strobe |
| err_addr_i | input | ADDR_W | Address of the corrected error |
| log_mode_i | input | 1 | 1 = log unique addresses in the table |
| ovf_only_i | input | 1 | With logging on: 1 = interrupt only on overflow |
| irq_en_i | input | 1 | Interrupt enable |
| pend_clr_i | input | 1 | Write-one-to-clear strobe for the pending bit |
| tbl_clr_i | input | 1 | Invalidate all entries and clear overflow |
| irq_o | output | 1 | Interrupt request |
| pend_o | output | 1 | Pending status |
| last_addr_o | output | ADDR_W | Most recent raw error address |
| entry_addr_o | output | DEPTH*ADDR_W | Packed table addresses, slot 0 in the low bits |
| entry_valid_o | output | DEPTH | Valid bit per slot |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench sends two addresses that differ only below the word boundary. A design that skipped alignment would spend two slots on them. It also fills the table to the limit in both logging modes. A design that confused the modes would raise the interrupt on every entry, or set the overflow flag with overflow detection off. The bench also fires a clear together with an error, and a pending-clear together with a new event. A wrong ordering would lose the new address or the interrupt. Finally it re-sends an address after a table clear. A design that compared stale, invalid entries would refuse to store it again.

// File: rtl/ce_log_pkg.sv
package ce_log_pkg;

    typedef enum logic [1:0] {
        MODE_EVERY = 2'd0,
        MODE_NEW   = 2'd1,
        MODE_OVF   = 2'd2
    } irq_mode_e;

    typedef struct packed {
        logic fresh;   // address stored in a free slot
        logic spill;   // new address met a full table with overflow detection on
    } log_evt_t;

    function automatic irq_mode_e pick_mode(input logic log_on, input logic ovf_only);
        if (!log_on)
            return MODE_EVERY;
        else if (ovf_only)
            return MODE_OVF;
        else
            return MODE_NEW;
    endfunction

endpackage

// File: rtl/ce_log_table.sv
module ce_log_table
    import ce_log_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr_i,
    input  logic                     wr_req_i,
    input  logic                     spill_en_i,
    input  logic [ADDR_W-1:0]        addr_i,
    output logic [DEPTH*ADDR_W-1:0]  entry_addr_o,
    output logic [DEPTH-1:0]         entry_valid_o,
    output logic                     ovf_o,
    output log_evt_t                 evt_o
);

    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [ADDR_W-1:0] slot_q [DEPTH];
    logic [DEPTH-1:0]  valid_q;
    logic [DEPTH-1:0]  live;
    logic [DEPTH-1:0]  match;
    logic              ovf_q;
    logic              hit;
    logic              full;
    logic [SLOT_W-1:0] free_idx;
    log_evt_t          evt;

    // clear takes effect before the lookup of the same cycle
    assign live = clr_i ? '0 : valid_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = live[g] && (slot_q[g] == addr_i);
    end

    assign hit  = |match;
    assign full = &live;

    always_comb begin
        logic found;
        found    = 1'b0;
        free_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!live[i] && !found) begin
                free_idx = SLOT_W'(i);
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        evt.fresh = wr_req_i && !hit && !full;
        evt.spill = wr_req_i && !hit && full && spill_en_i;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (evt.fresh && (free_idx == SLOT_W'(g))) begin
                slot_q[g] <= addr_i;
            end
        end
        assign entry_addr_o[g*ADDR_W +: ADDR_W] = slot_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            valid_q <= live | (evt.fresh ? (DEPTH'(1) << free_idx) : '0);
            ovf_q   <= (ovf_q && !clr_i) || evt.spill;
        end
    end

    assign entry_valid_o = valid_q;
    assign ovf_o         = ovf_q;
    assign evt_o         = evt;

endmodule

// File: rtl/ce_log_irq.sv
module ce_log_irq
    import ce_log_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      err_i,
    input  irq_mode_e mode_i,
    input  log_evt_t  evt_i,
    input  logic      irq_en_i,
    input  logic      pend_clr_i,
    output logic      pend_o,
    output logic      irq_o
);

    logic pend_q;
    logic fire;

    always_comb begin
        unique case (mode_i)
            MODE_EVERY: fire = err_i;
            MODE_NEW:   fire = evt_i.fresh;
            MODE_OVF:   fire = evt_i.spill;
            default:    fire = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (fire && irq_en_i)
            pend_q <= 1'b1;
        else if (pend_clr_i)
            pend_q <= 1'b0;
    end

    assign pend_o = pend_q;
    assign irq_o  = pend_q && irq_en_i;

endmodule

// File: rtl/ce_addr_log.sv
module ce_addr_log
    import ce_log_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4,
    parameter int ALIGN  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     err_valid_i,
    input  logic [ADDR_W-1:0]        err_addr_i,
    input  logic                     log_mode_i,
    input  logic                     ovf_only_i,
    input  logic                     irq_en_i,
    input  logic                     pend_clr_i,
    input  logic                     tbl_clr_i,
    output logic                     irq_o,
    output logic                     pend_o,
    output logic [ADDR_W-1:0]        last_addr_o,
    output logic [DEPTH*ADDR_W-1:0]  entry_addr_o,
    output logic [DEPTH-1:0]         entry_valid_o,
    output logic                     ovf_o
);

    localparam logic [ADDR_W-1:0] WORD_MASK = ~((ADDR_W'(1) << ALIGN) - ADDR_W'(1));

    logic [ADDR_W-1:0] word_addr;
    logic [ADDR_W-1:0] last_q;
    irq_mode_e         mode;
    log_evt_t          evt;

    assign word_addr = err_addr_i & WORD_MASK;
    assign mode      = pick_mode(log_mode_i, ovf_only_i);

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= '0;
        else if (err_valid_i)
            last_q <= err_addr_i;
    end

    assign last_addr_o = last_q;

    ce_log_table #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_table (
        .clk          (clk),
        .rst          (rst),
        .clr_i        (tbl_clr_i),
        .wr_req_i     (err_valid_i && log_mode_i),
        .spill_en_i   (ovf_only_i),
        .addr_i       (word_addr),
        .entry_addr_o (entry_addr_o),
        .entry_valid_o(entry_valid_o),
        .ovf_o        (ovf_o),
        .evt_o        (evt)
    );

    ce_log_irq i_irq (
        .clk       (clk),
        .rst       (rst),
        .err_i     (err_valid_i),
        .mode_i    (mode),
        .evt_i     (evt),
        .irq_en_i  (irq_en_i),
        .pend_clr_i(pend_clr_i),
        .pend_o    (pend_o),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/ce_log_chk.sv
module ce_log_chk #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4,
    parameter int ALIGN  = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    err_valid_i,
    input logic [ADDR_W-1:0]       err_addr_i,
    input logic                    log_mode_i,
    input logic                    irq_en_i,
    input logic                    pend_clr_i,
    input logic                    tbl_clr_i,
    input logic                    irq_o,
    input logic                    pend_o,
    input logic [ADDR_W-1:0]       last_addr_o,
    input logic [DEPTH*ADDR_W-1:0] entry_addr_o,
    input logic [DEPTH-1:0]        entry_valid_o,
    input logic                    ovf_o
);

    localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << ALIGN) - ADDR_W'(1);

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (pend_o && irq_en_i)); // R8

    AST_LAST_ADDR: assert property (@(posedge clk) disable iff (rst)
        err_valid_i |=> (last_addr_o == $past(err_addr_i))); // R6

    AST_EVERY_NO_LOG: assert property (@(posedge clk) disable iff (rst)
        (err_valid_i && !log_mode_i && !tbl_clr_i) |=> ($stable(entry_valid_o) && $stable(ovf_o))); // R2

    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (tbl_clr_i && !err_valid_i) |=> (entry_valid_o == '0 && !ovf_o)); // R10

    AST_CLR_THEN_LOG: assert property (@(posedge clk) disable iff (rst)
        (tbl_clr_i && err_valid_i && log_mode_i) |=> (entry_valid_o == DEPTH'(1))); // R11

    AST_PEND_CLR: assert property (@(posedge clk) disable iff (rst)
        (pend_clr_i && !err_valid_i) |=> !pend_o); // R9

    AST_OVF_FULL: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> (&entry_valid_o)); // R4

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
            entry_valid_o[i] |-> ((entry_addr_o[i*ADDR_W +: ADDR_W] & LOW_MASK) == '0)); // R1
        for (genvar j = i + 1; j < DEPTH; j++) begin : g_pair
            AST_NO_DUP: assert property (@(posedge clk) disable iff (rst)
                (entry_valid_o[i] && entry_valid_o[j]) |->
                (entry_addr_o[i*ADDR_W +: ADDR_W] != entry_addr_o[j*ADDR_W +: ADDR_W])); // R5
        end
    end

endmodule

bind ce_addr_log ce_log_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .ALIGN(ALIGN)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .err_valid_i  (err_valid_i),
    .err_addr_i   (err_addr_i),
    .log_mode_i   (log_mode_i),
    .irq_en_i     (irq_en_i),
    .pend_clr_i   (pend_clr_i),
    .tbl_clr_i    (tbl_clr_i),
    .irq_o        (irq_o),
    .pend_o       (pend_o),
    .last_addr_o  (last_addr_o),
    .entry_addr_o (entry_addr_o),
    .entry_valid_o(entry_valid_o),
    .ovf_o        (ovf_o)
);

// File: tb/test_ce_addr_log.sv
module test_ce_addr_log;

    localparam int ADDR_W = 16;
    localparam int DEPTH  = 4;
    localparam int ALIGN  = 2;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    err_valid_i = 1'b0;
    logic [ADDR_W-1:0]       err_addr_i = '0;
    logic                    log_mode_i = 1'b0;
    logic                    ovf_only_i = 1'b0;
    logic                    irq_en_i = 1'b1;
    logic                    pend_clr_i = 1'b0;
    logic                    tbl_clr_i = 1'b0;
    logic                    irq_o, pend_o, ovf_o;
    logic [ADDR_W-1:0]       last_addr_o;
    logic [DEPTH*ADDR_W-1:0] entry_addr_o;
    logic [DEPTH-1:0]        entry_valid_o;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 0;

    // reference model state
    int  m_tbl[$];
    bit  m_ovf, m_pend;
    int  m_last;

    always #10 clk = ~clk;

    ce_addr_log #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .ALIGN(ALIGN)) i_ce_addr_log (
        .clk(clk), .rst(rst), .err_valid_i(err_valid_i), .err_addr_i(err_addr_i),
        .log_mode_i(log_mode_i), .ovf_only_i(ovf_only_i), .irq_en_i(irq_en_i),
        .pend_clr_i(pend_clr_i), .tbl_clr_i(tbl_clr_i), .irq_o(irq_o), .pend_o(pend_o),
        .last_addr_o(last_addr_o), .entry_addr_o(entry_addr_o),
        .entry_valid_o(entry_valid_o), .ovf_o(ovf_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, updated on each clock
    always @(posedge clk) begin
        bit ev;
        bit hit;
        int a;
        ev = 0;
        if (rst) begin
            m_tbl.delete();
            m_ovf = 0; m_pend = 0; m_last = 0;
        end else begin
            if (tbl_clr_i) begin
                m_tbl.delete();
                m_ovf = 0;
            end
            if (err_valid_i) begin
                m_last = int'(err_addr_i);
                a = int'(err_addr_i) & ~((1 << ALIGN) - 1);
                if (!log_mode_i) begin
                    ev = 1;
                end else begin
                    hit = 0;
                    foreach (m_tbl[k]) if (m_tbl[k] == a) hit = 1;
                    if (!hit) begin
                        if (m_tbl.size() < DEPTH) begin
                            m_tbl.push_back(a);
                            if (!ovf_only_i) ev = 1;
                        end else if (ovf_only_i) begin
                            m_ovf = 1;
                            ev = 1;
                        end
                    end
                end
            end
            if (ev && irq_en_i) m_pend = 1;
            else if (pend_clr_i) m_pend = 0;
        end
    end

    // compare every cycle, away from the edge
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            chk(pend_o == m_pend, "R8 pend", pend_o, m_pend);
            chk(irq_o == (m_pend && irq_en_i), "R8 irq", irq_o, m_pend && irq_en_i);
            chk(ovf_o == m_ovf, "R10 ovf", ovf_o, m_ovf);
            chk(int'(last_addr_o) == m_last, "R6 last", last_addr_o, m_last);
            for (int i = 0; i < DEPTH; i++) begin
                chk(entry_valid_o[i] == (i < m_tbl.size()), "R7 valid", entry_valid_o[i], i < m_tbl.size());
                if (i < m_tbl.size())
                    chk(int'(entry_addr_o[i*ADDR_W +: ADDR_W]) == m_tbl[i], "R7 entry",
                        entry_addr_o[i*ADDR_W +: ADDR_W], m_tbl[i]);
            end
        end
    end

    // one cycle of stimulus; results are visible on return
    task automatic step(input bit e, input int a, input bit pc, input bit tc);
        @(negedge clk);
        err_valid_i = e;
        err_addr_i  = ADDR_W'(a);
        pend_clr_i  = pc;
        tbl_clr_i   = tc;
        @(posedge clk);
        #3;
        err_valid_i = 0;
        pend_clr_i  = 0;
        tbl_clr_i   = 0;
    endtask

    task automatic clear_pend();
        step(0, 0, 1, 0);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pend_o == 0 && irq_o == 0 && ovf_o == 0, "R12 flags", {pend_o, irq_o, ovf_o}, 0);
        chk(last_addr_o == 0 && entry_valid_o == 0 && entry_addr_o == 0, "R12 regs", entry_valid_o, 0);
        rst = 0;

        // every-error mode
        log_mode_i = 0; ovf_only_i = 0; irq_en_i = 1;
        step(1, 'h123, 0, 0);
        chk(pend_o == 1 && irq_o == 1, "R2 irq on error", pend_o, 1);
        chk(entry_valid_o == 0, "R2 no logging", entry_valid_o, 0);
        chk(last_addr_o == 'h123, "R6 raw addr", last_addr_o, 'h123);
        clear_pend();
        chk(pend_o == 0, "R9 w1c", pend_o, 0);

        // disabled interrupt
        @(negedge clk); irq_en_i = 0;
        step(1, 'h040, 0, 0);
        chk(pend_o == 0 && irq_o == 0, "R8 gated", pend_o, 0);
        @(negedge clk); irq_en_i = 1;

        // per-entry mode
        log_mode_i = 1;
        step(1, 'h100, 0, 0);
        chk(pend_o == 1 && entry_valid_o == 4'b0001, "R3 new entry irq", entry_valid_o, 1);
        chk(entry_addr_o[ADDR_W-1:0] == 'h100, "R7 slot0", entry_addr_o[ADDR_W-1:0], 'h100);
        clear_pend();
        step(1, 'h102, 0, 0);
        chk(entry_valid_o == 4'b0001 && pend_o == 0, "R1 same word no entry", entry_valid_o, 1);
        chk(last_addr_o == 'h102, "R6 raw kept", last_addr_o, 'h102);
        step(1, 'h104, 1, 0);
        chk(pend_o == 1, "R9 set beats clear", pend_o, 1);
        step(1, 'h108, 0, 0);
        step(1, 'h10C, 0, 0);
        chk(entry_valid_o == 4'b1111, "R7 full", entry_valid_o, 'hF);
        chk(entry_addr_o[3*ADDR_W +: ADDR_W] == 'h10C, "R7 slot3", entry_addr_o[3*ADDR_W +: ADDR_W], 'h10C);
        clear_pend();
        step(1, 'h110, 0, 0);
        chk(pend_o == 0 && ovf_o == 0, "R3 full no ovf", {pend_o, ovf_o}, 0);

        // clear together with an error
        step(1, 'h200, 0, 1);
        chk(entry_valid_o == 4'b0001, "R11 clear then log", entry_valid_o, 1);
        chk(entry_addr_o[ADDR_W-1:0] == 'h200, "R11 slot0 addr", entry_addr_o[ADDR_W-1:0], 'h200);

        // overflow-only mode
        ovf_only_i = 1;
        clear_pend();
        step(1, 'h204, 0, 0);
        step(1, 'h208, 0, 0);
        step(1, 'h20C, 0, 0);
        chk(pend_o == 0 && entry_valid_o == 4'b1111, "R4 no irq on entries", pend_o, 0);
        step(1, 'h210, 0, 0);
        chk(ovf_o == 1 && pend_o == 1, "R4 fifth distinct", {ovf_o, pend_o}, 3);
        clear_pend();
        step(1, 'h214, 0, 0);
        chk(ovf_o == 1 && entry_valid_o == 4'b1111, "R10 sticky drop", ovf_o, 1);
        clear_pend();
        step(1, 'h200, 0, 0);
        chk(pend_o == 0, "R5 dup when full", pend_o, 0);

        // table clear and re-log
        step(0, 0, 0, 1);
        chk(entry_valid_o == 0 && ovf_o == 0, "R10 table clear", entry_valid_o, 0);
        step(1, 'h204, 0, 0);
        chk(entry_valid_o == 4'b0001 && entry_addr_o[ADDR_W-1:0] == 'h204, "R5 stale ignored",
            entry_addr_o[ADDR_W-1:0], 'h204);

        // logging switched off leaves the table alone
        log_mode_i = 0;
        step(1, 'h300, 0, 0);
        chk(entry_valid_o == 4'b0001 && pend_o == 1, "R2 table untouched", entry_valid_o, 1);

        repeat (2) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule